// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces the processor reset and a watchdog fault flag for a digital subsystem. It takes a supply-good indication from an external monitor and holds the processor in reset while that flag is low. Once the supply is good, it keeps reset asserted for a fixed number of timebase ticks so the supply and the processor can settle.

A software-toggled watchdog line is synchronised and checked for edges in either direction. If no edge arrives within the watchdog period, the block issues a reset pulse of the same stretched length and drives the active-low fault flag low. The first period after any reset is always the long one. The short period is used only once software has shown it is running by producing an edge. All durations are counted in ticks of a timebase strobe, so the same logic works with any tick rate.

Top module: `sup_wdog_rst`

## Requirements
- R1: From the first clock edge that samples `supply_ok_i` low, `rst_n_o` is low, and it stays low for as long as `supply_ok_i` stays low.
- R2: After `supply_ok_i` returns high, `rst_n_o` stays low for exactly RST_TICKS sampled ticks (with `tick_i` high every cycle: low through cycle RST_TICKS-1 after the change, high at cycle RST_TICKS).
- R3: `rst_o` is at all times the logical inverse of `rst_n_o`.
- R4: After any reset ends, the first watchdog period is LONG_TICKS ticks, whatever `long_sel_i` selects. The counter starts from zero when reset ends, whether the reset came from the supply or from a timeout.
- R5: After the first synchronised edge on `wdi_i` that follows reset, the period is SHORT_TICKS when `long_sel_i` is 0 and LONG_TICKS when `long_sel_i` is 1. A timeout happens 3 + period cycles after the `wdi_i` change (two synchroniser stages plus one register).
- R6: A rising edge and a falling edge on `wdi_i` each restart the watchdog period from zero.
- R7: A timeout asserts reset for RST_TICKS ticks. With `wdi_i` held constant, timeouts repeat, each one LONG_TICKS ticks after the previous pulse ends.
- R8: `wdo_n_o` goes low in the same cycle as the reset pulse that a timeout starts. It stays low through that pulse and afterwards, until the next `wdi_i` edge takes it high.
- R9: While `supply_ok_i` is low, `wdo_n_o` is high, starting from the first clock edge that samples it low.
- R10: While `wd_en_i` is 0, the watchdog counter is held at zero, no watchdog reset occurs and `wdo_n_o` is high. After `wd_en_i` returns to 1, the first period is LONG_TICKS.
- R11: The reset-stretch and watchdog counters advance only in cycles with `tick_i` high. Without ticks, reset is never released and no timeout occurs.
- R12: While `rst_i` (synchronous, active high) is asserted, `rst_n_o` is low and `wdo_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset of the block itself |
| tick_i | input | 1 | Timebase strobe; one cycle high per tick |
| supply_ok_i | input | 1 | Supply-good flag from the external monitor, synchronous to clk_i |
| wdi_i | input | 1 | Watchdog kick line, asynchronous, either edge counts |
| wd_en_i | input | 1 | 1 enables the watchdog, 0 holds it disabled |
| long_sel_i | input | 1 | 1 selects the long period, 0 the short period |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| wdo_n_o | output | 1 | Watchdog fault flag, active low |

## Verification
The properties assume that `supply_ok_i`, `wd_en_i`, `long_sel_i` and `tick_i` are already synchronous to `clk_i` and change only between edges; only `wdi_i` may arrive asynchronously. The bench keeps to this by driving every input just after a falling clock edge. It changes `wdi_i` only once the previous edge has cleared the synchroniser. Ticks stay high every cycle except in deliberate stall windows, so each expected cycle follows directly from the tick counts in the requirements.

// File: rtl/sup_wdog_pkg.sv
package sup_wdog_pkg;

    // Watchdog phase: unarmed runs the long period, armed honours the select pin
    typedef enum logic [0:0] {
        WD_UNARMED = 1'b0,
        WD_ARMED   = 1'b1
    } wd_phase_e;

    // Control bundle into the watchdog timer
    typedef struct packed {
        logic hold;       // counter forced to zero, phase back to unarmed
        logic clr_fault;  // fault flag forced inactive
        logic use_long;   // long period requested once armed
    } wd_ctrl_t;

    // Status bundle out of the watchdog timer
    typedef struct packed {
        logic timeout;    // single-cycle expiry strobe
        logic fault;      // sticky fault, cleared by a kick
    } wd_stat_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_wdi_sync.sv
module sup_wdi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic toggle_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    // stage[0..STAGES-1] synchronise, stage[STAGES] holds the previous value
    logic [DEPTH-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[g] <= 1'b0;
                    else       stage_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[g] <= 1'b0;
                    else       stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign toggle_o = stage_q[STAGES-1] ^ stage_q[STAGES];

endmodule

// File: rtl/sup_rst_stretch.sv
module sup_rst_stretch #(
    parameter int unsigned RST_TICKS = 200
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic supply_ok_i,
    input  logic trip_i,
    output logic active_o
);
    localparam int unsigned   RW   = sup_wdog_pkg::cnt_width(RST_TICKS);
    localparam logic [RW-1:0] LAST = RW'(RST_TICKS - 1);

    logic [RW-1:0] cnt_q;
    logic          act_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (!supply_ok_i || trip_i) begin
            // bad supply or watchdog expiry: (re)start the hold-off
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (act_q && tick_i) begin
            if (cnt_q == LAST) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + RW'(1);
            end
        end
    end

    assign active_o = act_q;

endmodule

// File: rtl/sup_wdog_timer.sv
module sup_wdog_timer
    import sup_wdog_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 100,
    parameter int unsigned LONG_TICKS  = 1600
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     tick_i,
    input  wd_ctrl_t ctrl_i,
    input  logic     toggle_i,
    output wd_stat_t stat_o
);
    localparam int unsigned   CW         = cnt_width(max2(SHORT_TICKS, LONG_TICKS));
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

    wd_phase_e     phase_q;
    logic [CW-1:0] cnt_q;
    logic          fault_q;
    logic [CW-1:0] last;
    logic          expire;

    always_comb begin
        last   = (phase_q == WD_ARMED && !ctrl_i.use_long) ? SHORT_LAST : LONG_LAST;
        // >= covers a select change from long to short in mid-period
        expire = !ctrl_i.hold && !toggle_i && tick_i && (cnt_q >= last);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || ctrl_i.hold) begin
            phase_q <= WD_UNARMED;
            cnt_q   <= '0;
        end else if (toggle_i) begin
            phase_q <= WD_ARMED;
            cnt_q   <= '0;
        end else if (tick_i) begin
            if (expire) cnt_q <= '0;
            else        cnt_q <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || ctrl_i.clr_fault) fault_q <= 1'b0;
        else if (toggle_i)             fault_q <= 1'b0;
        else if (expire)               fault_q <= 1'b1;
    end

    always_comb begin
        stat_o.timeout = expire;
        stat_o.fault   = fault_q;
    end

endmodule

// File: rtl/sup_wdog_rst.sv
module sup_wdog_rst
    import sup_wdog_pkg::*;
#(
    parameter int unsigned RST_TICKS   = 200,
    parameter int unsigned SHORT_TICKS = 100,
    parameter int unsigned LONG_TICKS  = 1600,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic supply_ok_i,
    input  logic wdi_i,
    input  logic wd_en_i,
    input  logic long_sel_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic wdo_n_o
);
    logic     kick;
    logic     rst_act;
    wd_ctrl_t wd_ctrl;
    wd_stat_t wd_stat;

    sup_wdi_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .async_i  (wdi_i),
        .toggle_o (kick)
    );

    always_comb begin
        wd_ctrl.hold      = rst_act | ~wd_en_i;
        wd_ctrl.clr_fault = ~supply_ok_i | ~wd_en_i;
        wd_ctrl.use_long  = long_sel_i;
    end

    sup_wdog_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick_i),
        .ctrl_i   (wd_ctrl),
        .toggle_i (kick),
        .stat_o   (wd_stat)
    );

    sup_rst_stretch #(
        .RST_TICKS (RST_TICKS)
    ) u_stretch (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick_i),
        .supply_ok_i (supply_ok_i),
        .trip_i      (wd_stat.timeout),
        .active_o    (rst_act)
    );

    assign rst_n_o = ~rst_act;
    assign rst_o   = rst_act;
    assign wdo_n_o = ~wd_stat.fault;

endmodule

// File: rtl/sup_wdog_chk.sv
module sup_wdog_chk #(
    parameter int unsigned RST_TICKS = 200
) (
    input logic clk_i,
    input logic rst_i,
    input logic tick_i,
    input logic supply_ok_i,
    input logic wd_en_i,
    input logic rst_n_o,
    input logic wdo_n_o
);
    // ticks seen while reset is low, saturating at the stretch length
    int unsigned low_ticks;

    always_ff @(posedge clk_i) begin
        if (rst_i || rst_n_o)
            low_ticks <= 0;
        else if (tick_i && low_ticks < RST_TICKS)
            low_ticks <= low_ticks + 1;
    end

    AST_SUPPLY_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        !supply_ok_i |=> !rst_n_o);  // R1

    AST_RESET_STRETCH: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o) |-> (low_ticks >= RST_TICKS));  // R2

    AST_FAULT_WITH_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(wdo_n_o) |-> $fell(rst_n_o));  // R8

    AST_NO_FAULT_BAD_SUPPLY: assert property (@(posedge clk_i) disable iff (rst_i)
        !supply_ok_i |=> wdo_n_o);  // R9

    AST_NO_FAULT_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
        !wd_en_i |=> wdo_n_o);  // R10

    AST_NO_RELEASE_NO_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !rst_n_o) |=> !rst_n_o);  // R11

endmodule

bind sup_wdog_rst sup_wdog_chk #(
    .RST_TICKS (RST_TICKS)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .wd_en_i     (wd_en_i),
    .rst_n_o     (rst_n_o),
    .wdo_n_o     (wdo_n_o)
);

// File: tb/sup_wdog_rst_tb.sv
module sup_wdog_rst_tb;
    localparam int unsigned RST   = 4;
    localparam int unsigned SHORT = 6;
    localparam int unsigned LONG  = 15;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic tick = 1'b1;
    logic supply_ok = 1'b0;
    logic wdi = 1'b0;
    logic wd_en = 1'b1;
    logic long_sel = 1'b0;
    logic rst_n, rst_hi, wdo_n;

    int unsigned cyc = 0;
    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned t;

    typedef struct {
        int unsigned at;
        logic        rn;
        logic        wn;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    sup_wdog_rst #(
        .RST_TICKS   (RST),
        .SHORT_TICKS (SHORT),
        .LONG_TICKS  (LONG)
    ) u_dut (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .tick_i      (tick),
        .supply_ok_i (supply_ok),
        .wdi_i       (wdi),
        .wd_en_i     (wd_en),
        .long_sel_i  (long_sel),
        .rst_n_o     (rst_n),
        .rst_o       (rst_hi),
        .wdo_n_o     (wdo_n)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop expectations that fall due in this cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            cur = sb_q.pop_front();
            checks++;
            if (cur.at != cyc || rst_n !== cur.rn || wdo_n !== cur.wn) begin
                errors++;
                $display("FAIL %s cyc %0d: rst_n=%b wdo_n=%b expected rst_n=%b wdo_n=%b (due %0d)",
                         cur.req, cyc, rst_n, wdo_n, cur.rn, cur.wn, cur.at);
            end
            checks++;
            if (rst_hi !== ~cur.rn) begin  // R3
                errors++;
                $display("FAIL R3 cyc %0d: rst_o=%b expected %b", cyc, rst_hi, ~cur.rn);
            end
        end
    end

    task automatic expect_at(input int unsigned d, input logic rn, input logic wn, input string req);
        exp_t e;
        e.at  = cyc + d;
        e.rn  = rn;
        e.wn  = wn;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_until(input int unsigned when);
        while (cyc < when) @(negedge clk);
    endtask

    task automatic wait_drain();
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung at cyc %0d, expected completion", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R12: block reset state
        repeat (3) @(negedge clk);
        expect_at(1, 1'b0, 1'b1, "R12");
        wait_drain();
        rst_i = 1'b0;

        // R1: supply still bad
        repeat (5) @(negedge clk);
        expect_at(1, 1'b0, 1'b1, "R1");
        wait_drain();

        // R2, R4, R7, R8: supply good, input stuck, short selected
        supply_ok = 1'b1;
        t = cyc;
        expect_at(RST - 1,          1'b0, 1'b1, "R2");
        expect_at(RST,              1'b1, 1'b1, "R2");
        expect_at(RST + LONG - 1,   1'b1, 1'b1, "R4");
        expect_at(RST + LONG,       1'b0, 1'b0, "R4");
        expect_at(2*RST + LONG - 1, 1'b0, 1'b0, "R7");
        expect_at(2*RST + LONG,     1'b1, 1'b0, "R8");
        expect_at(2*RST + 2*LONG - 1, 1'b1, 1'b0, "R8");
        expect_at(2*RST + 2*LONG,   1'b0, 1'b0, "R7");
        expect_at(3*RST + 2*LONG,   1'b1, 1'b0, "R7");
        wait_until(t + 3*RST + 2*LONG + 2);

        // R8 clear on rising kick, R6 restart on falling kick, R5 short period
        wdi = 1'b1;
        t = cyc;
        expect_at(2, 1'b1, 1'b0, "R8");
        expect_at(3, 1'b1, 1'b1, "R8");
        wait_until(t + 4);
        wdi = 1'b0;
        t = cyc;
        expect_at(SHORT,     1'b1, 1'b1, "R6");
        expect_at(SHORT + 2, 1'b1, 1'b1, "R5");
        expect_at(SHORT + 3, 1'b0, 1'b0, "R5");
        wait_until(t + SHORT + 3 + RST + 1);

        // R5: long period selected after a kick
        long_sel = 1'b1;
        wdi = 1'b1;
        t = cyc;
        expect_at(SHORT + 3, 1'b1, 1'b1, "R5");
        expect_at(LONG + 2,  1'b1, 1'b1, "R5");
        expect_at(LONG + 3,  1'b0, 1'b0, "R5");
        wait_until(t + LONG + 3 + RST + 1);

        // R9: supply drop clears the fault flag
        supply_ok = 1'b0;
        expect_at(1, 1'b0, 1'b1, "R9");
        expect_at(2, 1'b0, 1'b1, "R1");
        wait_drain();

        // R11: no ticks, no release and no timeout
        tick = 1'b0;
        supply_ok = 1'b1;
        t = cyc;
        expect_at(20, 1'b0, 1'b1, "R11");
        wait_until(t + 20);
        tick = 1'b1;
        t = cyc;
        expect_at(RST - 1, 1'b0, 1'b1, "R11");
        expect_at(RST,     1'b1, 1'b1, "R11");
        wait_until(t + RST);
        tick = 1'b0;
        t = cyc;
        expect_at(3*LONG, 1'b1, 1'b1, "R11");
        wait_until(t + 3*LONG);
        tick = 1'b1;
        t = cyc;
        expect_at(LONG - 1, 1'b1, 1'b1, "R11");
        expect_at(LONG,     1'b0, 1'b0, "R11");
        wait_until(t + LONG + RST + 1);

        // R10: disabled watchdog
        wd_en = 1'b0;
        t = cyc;
        expect_at(1,      1'b1, 1'b1, "R10");
        expect_at(3*LONG, 1'b1, 1'b1, "R10");
        wait_until(t + 3*LONG);
        wd_en = 1'b1;
        expect_at(LONG - 1, 1'b1, 1'b1, "R10");
        expect_at(LONG,     1'b0, 1'b0, "R10");
        wait_drain();

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule